// File: doc/BRIEF.md
# Register Initialization Command Sequencer

This block brings a chip region into a known state by executing a stored list of 64-bit initialization records. Software or a boot controller gives it a start index and an end index. The sequencer then fetches each record in that range from a record ROM and decodes the opcode. It carries out each record as accesses on a simple register bus. The supported operations are a single read, a single write, an indirect write through an address/data window pair, string copies from a data ROM (direct or through the window pair), zero fills, and burst string copies.

Zero fills and burst copies are split into chunks of at most `MAX_BURST` words. The first word of every chunk is marked on a sideband pin. The module checks each such operation against a staging-buffer limit of `STAGE_WORDS` words and rejects it if it is too large. An opcode it does not recognise, or a rejected operation, sets a sticky error flag. Execution then carries on with the next record. The block pulses `done` when the range is exhausted.

Every register access is a valid/ready transfer. `bus_rd` or `bus_wr` is the valid. Address, write data, strobes and the chunk marker stay frozen until a clock edge that sees `bus_ready` high. The bus may hold `bus_ready` low for any number of cycles. Both ROMs have a synchronous read with one cycle of latency.

Top module: `reginit_seq`

## Requirements
- R1: Records with indices from `first_idx` up to but not including `last_idx` are fetched through `rec_addr` and executed in increasing index order. Within `rec_data`, bits [7:0] hold the opcode, bits [31:8] the 24-bit target offset, and bits [63:32] the argument word. An empty range (first >= last) executes nothing.
- R2: Opcode 1 makes one bus read at the offset. The returned data is not used, and no write follows.
- R3: Opcode 2 makes one bus write of the argument word to the offset.
- R4: Opcode 3 makes two writes. The first writes the offset, zero-extended to 32 bits, to `WIN_ADDR_REG`. The second writes the argument word to `WIN_DATA_REG`.
- R5: Opcode 4 copies `n` words. `n` is argument bits [31:16] and the data offset `d` is bits [15:0]. Word `i`, read from data ROM address `d+i`, is written to offset + 4*i (24-bit wrap). When `n` is 0, the record makes no access.
- R6: Opcode 5 performs, for each word `i` of the R5 layout, an R4-style pair. The pair writes address offset + 4*i to `WIN_ADDR_REG`, then the data word to `WIN_DATA_REG`.
- R7: Opcode 6 writes zero to `len` words (the whole argument word) at offset + 4*i. `bus_sob` is high exactly on the words where i mod `MAX_BURST` is 0. When `len` is 0, the record makes no access.
- R8: Opcode 8 copies data in the R5 layout, with `bus_sob` marking chunks as in R7.
- R9: An opcode 6 or opcode 8 record whose word count exceeds `STAGE_WORDS` makes no access and sets `err`. A count equal to the limit is executed.
- R10: Opcode 7, opcode 0 and opcodes 9 to 255 make no access and set `err`. The following records still execute.
- R11: Once `bus_rd` or `bus_wr` is raised, `bus_addr`, `bus_wdata`, `bus_sob` and the strobes hold until a clock edge with `bus_ready` high. `bus_rd` and `bus_wr` are never high together.
- R12: `start` is honoured only when the sequencer is idle, and it clears `err`. `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse raised with `busy` low. There is no bus activity while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run over the given index range |
| first_idx | input | IDX_W | First record index executed |
| last_idx | input | IDX_W | Index one past the last record |
| rec_addr | output | IDX_W | Record ROM read address |
| rec_data | input | 64 | Record ROM data, one cycle after address |
| dat_addr | output | 16 | Data ROM read address |
| dat_rdata | input | 32 | Data ROM data, one cycle after address |
| bus_addr | output | 24 | Register bus address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rd | output | 1 | Read request (valid) |
| bus_wr | output | 1 | Write request (valid) |
| bus_sob | output | 1 | First word of a fill or burst-copy chunk |
| bus_ready | input | 1 | Bus accepts the current request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |
| err | output | 1 | Sticky error flag for the current run |

## Verification
A corrupted word counter or address stepper shows up as a bus access whose address or data differs from the next one expected. It can also show up as a stray or missing access. Either is visible on the very handshake where it occurs, because every accepted transfer is compared against a behavioural queue. A chunk counter that drifts moves `bus_sob` off a multiple of `MAX_BURST`. A broken decode shows up as a wrong `err` state, or as traffic from a record that should have been skipped. A control state machine that loses its place shows up as a missing or doubled `done`, or as a `start` honoured mid-run; these appear within a few cycles of the run's end.

// File: rtl/reginit_pkg.sv
package reginit_pkg;
  localparam int OFF_W  = 24;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;
  localparam int REC_W  = 64;

  typedef enum logic [7:0] {
    OPC_RD      = 8'd1,
    OPC_WR      = 8'd2,
    OPC_MBX_WR  = 8'd3,
    OPC_STR     = 8'd4,
    OPC_MBX_STR = 8'd5,
    OPC_ZERO    = 8'd6,
    OPC_ZIP     = 8'd7,
    OPC_BSTR    = 8'd8
  } opcode_e;

  typedef enum logic [2:0] {
    ACC_RD, ACC_WR, ACC_MBX_WR, ACC_STR, ACC_MBX_STR, ACC_FILL, ACC_BSTR
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e          kind;
    logic [OFF_W-1:0]   base;
    logic [CNT_W-1:0]   doff;
    logic [CNT_W-1:0]   cnt;
    logic [WORD_W-1:0]  value;
  } job_t;

  function automatic logic kind_uses_rom(acc_kind_e k);
    return (k == ACC_STR) || (k == ACC_MBX_STR) || (k == ACC_BSTR);
  endfunction

  function automatic logic kind_is_mbx(acc_kind_e k);
    return (k == ACC_MBX_WR) || (k == ACC_MBX_STR);
  endfunction

  function automatic logic kind_is_burst(acc_kind_e k);
    return (k == ACC_FILL) || (k == ACC_BSTR);
  endfunction
endpackage

// File: rtl/reginit_decode.sv
module reginit_decode
  import reginit_pkg::*;
#(
  parameter int STAGE_WORDS = 64
) (
  input  logic [REC_W-1:0] rec,
  output job_t             job,
  output logic             bad_op,
  output logic             too_big
);
  logic [7:0]        opc;
  logic [OFF_W-1:0]  off;
  logic [WORD_W-1:0] arg;

  assign opc = rec[7:0];
  assign off = rec[31:8];
  assign arg = rec[63:32];

  always_comb begin
    job.kind  = ACC_WR;
    job.base  = off;
    job.doff  = arg[15:0];
    job.cnt   = arg[31:16];
    job.value = arg;
    bad_op    = 1'b0;
    too_big   = 1'b0;
    case (opc)
      OPC_RD: begin
        job.kind = ACC_RD;
        job.cnt  = CNT_W'(1);
      end
      OPC_WR: begin
        job.kind = ACC_WR;
        job.cnt  = CNT_W'(1);
      end
      OPC_MBX_WR: begin
        job.kind = ACC_MBX_WR;
        job.cnt  = CNT_W'(1);
      end
      OPC_STR:     job.kind = ACC_STR;
      OPC_MBX_STR: job.kind = ACC_MBX_STR;
      OPC_ZERO: begin
        job.kind = ACC_FILL;
        job.cnt  = arg[15:0];
        too_big  = arg > WORD_W'(STAGE_WORDS);
      end
      OPC_BSTR: begin
        job.kind = ACC_BSTR;
        too_big  = arg[31:16] > CNT_W'(STAGE_WORDS);
      end
      default: bad_op = 1'b1;
    endcase
  end
endmodule

// File: rtl/reginit_walker.sv
module reginit_walker
  import reginit_pkg::*;
#(
  parameter int               MAX_BURST    = 16,
  parameter logic [OFF_W-1:0] WIN_ADDR_REG = 24'h002000,
  parameter logic [OFF_W-1:0] WIN_DATA_REG = 24'h002004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  job_t              job,
  output logic              fin,
  output logic [CNT_W-1:0]  dat_addr,
  input  logic [WORD_W-1:0] dat_rdata,
  output logic [OFF_W-1:0]  bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_sob,
  input  logic              bus_ready
);
  localparam int BP_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;
  localparam logic [BP_W-1:0] BP_LAST = BP_W'(MAX_BURST - 1);

  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_LOAD, W_REQ} wstate_e;

  wstate_e           st;
  job_t              jq;
  logic [CNT_W-1:0]  idx;
  logic [BP_W-1:0]   bpos;
  logic [OFF_W-1:0]  cur;
  logic              mb_ph;
  logic [WORD_W-1:0] word_q;
  logic              rom_k, mbx_k, brst_k, last_word;
  logic [WORD_W-1:0] ld_word;

  assign rom_k     = kind_uses_rom(jq.kind);
  assign mbx_k     = kind_is_mbx(jq.kind);
  assign brst_k    = kind_is_burst(jq.kind);
  assign last_word = (idx + 1'b1) == jq.cnt;
  assign dat_addr  = jq.doff + idx;

  always_comb begin
    if (rom_k)                    ld_word = dat_rdata;
    else if (jq.kind == ACC_FILL) ld_word = '0;
    else                          ld_word = jq.value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      jq        <= '0;
      idx       <= '0;
      bpos      <= '0;
      cur       <= '0;
      mb_ph     <= 1'b0;
      word_q    <= '0;
      fin       <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_sob   <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        W_IDLE: begin
          if (go) begin
            jq    <= job;
            idx   <= '0;
            bpos  <= '0;
            cur   <= job.base;
            mb_ph <= 1'b0;
            if (job.cnt == '0)              fin <= 1'b1;
            else if (kind_uses_rom(job.kind)) st <= W_FETCH;
            else                              st <= W_LOAD;
          end
        end
        W_FETCH: st <= W_LOAD;
        W_LOAD: begin
          word_q  <= ld_word;
          bus_sob <= brst_k && (bpos == '0);
          if (jq.kind == ACC_RD) begin
            bus_rd    <= 1'b1;
            bus_addr  <= cur;
            bus_wdata <= '0;
          end else if (mbx_k) begin
            bus_wr    <= 1'b1;
            bus_addr  <= WIN_ADDR_REG;
            bus_wdata <= WORD_W'(cur);
          end else begin
            bus_wr    <= 1'b1;
            bus_addr  <= cur;
            bus_wdata <= ld_word;
          end
          st <= W_REQ;
        end
        W_REQ: begin
          if (bus_ready) begin
            if (mbx_k && !mb_ph) begin
              mb_ph     <= 1'b1;
              bus_addr  <= WIN_DATA_REG;
              bus_wdata <= word_q;
            end else begin
              bus_rd  <= 1'b0;
              bus_wr  <= 1'b0;
              bus_sob <= 1'b0;
              mb_ph   <= 1'b0;
              idx     <= idx + 1'b1;
              cur     <= cur + OFF_W'(4);
              bpos    <= (bpos == BP_LAST) ? '0 : bpos + 1'b1;
              if (last_word) begin
                fin <= 1'b1;
                st  <= W_IDLE;
              end else begin
                st <= rom_k ? W_FETCH : W_LOAD;
              end
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !bus_ready) |=>
      ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_rd) &&
       $stable(bus_wr) && $stable(bus_sob)));

  // R11
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));

  // R7
  sob_on_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sob |-> bus_wr);

  // R7
  fill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && jq.kind == ACC_FILL) |-> (bus_wdata == '0));

  // R4
  mbx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ready && mbx_k && !mb_ph) |=>
      (bus_wr && bus_addr == WIN_DATA_REG));
endmodule

// File: rtl/reginit_ctrl.sv
module reginit_ctrl #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] rec_addr,
  input  logic             bad_op,
  input  logic             too_big,
  output logic             go,
  input  logic             fin,
  output logic             busy,
  output logic             done,
  output logic             err
);
  typedef enum logic [1:0] {C_IDLE, C_CHECK, C_DEC, C_RUN} cstate_e;

  cstate_e          st;
  logic [IDX_W-1:0] idx_q, end_q;
  logic             skip;

  assign skip     = bad_op || too_big;
  assign go       = (st == C_DEC) && !skip;
  assign rec_addr = idx_q;
  assign busy     = (st != C_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= C_IDLE;
      idx_q <= '0;
      end_q <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        C_IDLE: begin
          if (start) begin
            idx_q <= first_idx;
            end_q <= last_idx;
            err   <= 1'b0;
            st    <= C_CHECK;
          end
        end
        C_CHECK: begin
          if (idx_q >= end_q) begin
            done <= 1'b1;
            st   <= C_IDLE;
          end else begin
            st <= C_DEC;
          end
        end
        C_DEC: begin
          if (skip) begin
            err   <= 1'b1;
            idx_q <= idx_q + 1'b1;
            st    <= C_CHECK;
          end else begin
            st <= C_RUN;
          end
        end
        C_RUN: begin
          if (fin) begin
            idx_q <= idx_q + 1'b1;
            st    <= C_CHECK;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DEC) |-> (idx_q < end_q));
endmodule

// File: rtl/reginit_seq.sv
module reginit_seq
  import reginit_pkg::*;
#(
  parameter int               IDX_W        = 8,
  parameter int               MAX_BURST    = 16,
  parameter int               STAGE_WORDS  = 64,
  parameter logic [OFF_W-1:0] WIN_ADDR_REG = 24'h002000,
  parameter logic [OFF_W-1:0] WIN_DATA_REG = 24'h002004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  first_idx,
  input  logic [IDX_W-1:0]  last_idx,
  output logic [IDX_W-1:0]  rec_addr,
  input  logic [REC_W-1:0]  rec_data,
  output logic [CNT_W-1:0]  dat_addr,
  input  logic [WORD_W-1:0] dat_rdata,
  output logic [OFF_W-1:0]  bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_sob,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done,
  output logic              err
);
  job_t job;
  logic bad_op, too_big, go, fin;

  reginit_decode #(.STAGE_WORDS(STAGE_WORDS)) u_dec (
    .rec     (rec_data),
    .job     (job),
    .bad_op  (bad_op),
    .too_big (too_big)
  );

  reginit_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .first_idx (first_idx),
    .last_idx  (last_idx),
    .rec_addr  (rec_addr),
    .bad_op    (bad_op),
    .too_big   (too_big),
    .go        (go),
    .fin       (fin),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  reginit_walker #(
    .MAX_BURST    (MAX_BURST),
    .WIN_ADDR_REG (WIN_ADDR_REG),
    .WIN_DATA_REG (WIN_DATA_REG)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .job       (job),
    .fin       (fin),
    .dat_addr  (dat_addr),
    .dat_rdata (dat_rdata),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_sob   (bus_sob),
    .bus_ready (bus_ready)
  );

  // R12
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> busy);
endmodule

// File: tb/reginit_seq_test.sv
`timescale 1ns/1ps
module reginit_seq_test;
  localparam int          IDX_W    = 8;
  localparam int          MB       = 16;
  localparam int          STAGE    = 64;
  localparam logic [23:0] WIN_A    = 24'h002000;
  localparam logic [23:0] WIN_D    = 24'h002004;
  localparam int          WATCHDOG = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [IDX_W-1:0]  first_idx = '0, last_idx = '0;
  logic [IDX_W-1:0]  rec_addr;
  logic [63:0]       rec_data = '0;
  logic [15:0]       dat_addr;
  logic [31:0]       dat_rdata = '0;
  logic [23:0]       bus_addr;
  logic [31:0]       bus_wdata;
  logic              bus_rd, bus_wr, bus_sob;
  logic              bus_ready = 1'b0;
  logic              busy, done, err;

  always #5 clk = ~clk;

  reginit_seq #(
    .IDX_W(IDX_W), .MAX_BURST(MB), .STAGE_WORDS(STAGE),
    .WIN_ADDR_REG(WIN_A), .WIN_DATA_REG(WIN_D)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_idx(first_idx),
    .last_idx(last_idx), .rec_addr(rec_addr), .rec_data(rec_data),
    .dat_addr(dat_addr), .dat_rdata(dat_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_sob(bus_sob), .bus_ready(bus_ready), .busy(busy), .done(done),
    .err(err)
  );

  // ROM models: synchronous read, one cycle of latency
  logic [63:0] rec_rom [0:63];

  function automatic logic [31:0] dat_val(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  always @(posedge clk) begin
    rec_data  <= rec_rom[rec_addr[5:0]];
    dat_rdata <= dat_val(dat_addr);
  end

  function automatic logic [63:0] mk(input logic [7:0] op, input logic [23:0] off,
                                     input logic [31:0] arg);
    return {arg, off, op};
  endfunction

  int n_chk = 0, n_bad = 0, cyc = 0, done_cnt = 0, ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [57:0] q [$];
  int          qt [$];
  bit          exp_err;
  bit          prev_wait = 0;
  logic [23:0] p_addr;
  logic [31:0] p_data;
  logic        p_rd, p_wr, p_sob;

  task automatic check(input bit ok, input int rq, input string msg,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: got %0h expected %0h", rq, msg, act, exp);
    end
  endtask

  task automatic push(input bit rd, input bit sob, input logic [23:0] a,
                      input logic [31:0] d, input int tag);
    q.push_back({rd, sob, a, d});
    qt.push_back(tag);
  endtask

  // Behavioural reference: expected accesses of one run, in order (R1)
  task automatic build_expect(input logic [7:0] f, input logic [7:0] l);
    exp_err = 0;
    q.delete();
    qt.delete();
    for (int i = int'(f); i < int'(l); i++) begin
      logic [63:0] r;
      logic [7:0]  op;
      logic [23:0] off;
      logic [31:0] w1;
      logic [15:0] doff, n;
      r = rec_rom[i];
      op = r[7:0]; off = r[31:8]; w1 = r[63:32];
      doff = w1[15:0]; n = w1[31:16];
      case (op)
        8'd1: push(1, 0, off, 32'h0, 2);                        // R2
        8'd2: push(0, 0, off, w1, 3);                           // R3
        8'd3: begin                                             // R4
          push(0, 0, WIN_A, {8'h0, off}, 4);
          push(0, 0, WIN_D, w1, 4);
        end
        8'd4: for (int k = 0; k < int'(n); k++)                 // R5
          push(0, 0, off + 24'(4*k), dat_val(doff + 16'(k)), 5);
        8'd5: for (int k = 0; k < int'(n); k++) begin           // R6
          push(0, 0, WIN_A, {8'h0, off + 24'(4*k)}, 6);
          push(0, 0, WIN_D, dat_val(doff + 16'(k)), 6);
        end
        8'd6: begin                                             // R7, R9
          if (w1 > 32'(STAGE)) exp_err = 1;
          else for (int k = 0; k < int'(w1); k++)
            push(0, (k % MB) == 0, off + 24'(4*k), 32'h0, 7);
        end
        8'd8: begin                                             // R8, R9
          if (n > 16'(STAGE)) exp_err = 1;
          else for (int k = 0; k < int'(n); k++)
            push(0, (k % MB) == 0, off + 24'(4*k), dat_val(doff + 16'(k)), 8);
        end
        default: exp_err = 1;                                   // R10
      endcase
    end
  endtask

  // Per-clock monitor: drives ready, compares each handshake with the model
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ready = 1'b0;
      prev_wait = 0;
    end else begin
      bit rdy;
      cyc++;
      if (cyc > WATCHDOG) begin
        n_chk++; n_bad++;
        $display("FAIL R12 watchdog: got %0d expected %0d", cyc, WATCHDOG);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (done) begin
        done_cnt++;
        check(!busy, 12, "busy low with done", 64'(busy), 64'h0);
      end
      // R11: a stalled request must be unchanged
      if (prev_wait)
        check(bus_rd == p_rd && bus_wr == p_wr && bus_addr == p_addr &&
              bus_wdata == p_data && bus_sob == p_sob, 11, "held request",
              {bus_rd, bus_wr, bus_sob, bus_addr, bus_wdata},
              {p_rd, p_wr, p_sob, p_addr, p_data});
      if (bus_rd && bus_wr)
        check(0, 11, "read and write together", 64'h3, 64'h1);
      if (ready_mode == 0)      rdy = 1'b1;
      else if (ready_mode == 1) rdy = lfsr[0];
      else                      rdy = (lfsr[2:0] == 3'd0);
      bus_ready = rdy;
      if ((bus_rd || bus_wr) && rdy) begin
        if (q.size() == 0) begin
          check(0, 10, "unexpected access", {bus_rd, bus_sob, bus_addr, bus_wdata}, 64'h0);
        end else begin
          logic [57:0] e;
          int tg;
          bit ok;
          e = q.pop_front();
          tg = qt.pop_front();
          ok = (bus_rd == e[57]) && (bus_wr == !e[57]) && (bus_sob == e[56]) &&
               (bus_addr == e[55:32]) && (e[57] || bus_wdata == e[31:0]);
          check(ok, tg, "access", {bus_rd, bus_sob, bus_addr, bus_wdata}, e);
        end
      end
      prev_wait = (bus_rd || bus_wr) && !rdy;
      p_rd = bus_rd; p_wr = bus_wr; p_sob = bus_sob;
      p_addr = bus_addr; p_data = bus_wdata;
    end
  end

  task automatic run(input logic [7:0] f, input logic [7:0] l, input int rmode,
                     input bit poke, input int etag);
    int waitc;
    build_expect(f, l);
    ready_mode = rmode;
    done_cnt = 0;
    @(negedge clk); #1;
    start = 1'b1; first_idx = f; last_idx = l;
    @(negedge clk); #1;
    start = 1'b0;
    check(busy == 1'b1, 12, "busy after start", 64'(busy), 64'h1);
    waitc = 0;
    while (done_cnt == 0 && waitc < 20000) begin
      @(negedge clk); #1;
      waitc++;
      // R12: start while busy must be ignored (range 12..13 would clear/alter err)
      if (poke && waitc == 30) begin start = 1'b1; first_idx = 8'd12; last_idx = 8'd13; end
      if (poke && waitc == 31) start = 1'b0;
    end
    check(done_cnt != 0, 12, "run finished", 64'(waitc), 64'h0);
    repeat (3) @(negedge clk);
    #1;
    check(done_cnt == 1, 12, "single done pulse", 64'(done_cnt), 64'h1);
    check(q.size() == 0, 1, "all expected accesses seen", 64'(q.size()), 64'h0);
    check(err == exp_err, etag, "error flag", 64'(err), 64'(exp_err));
    check(!busy, 12, "idle after run", 64'(busy), 64'h0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) rec_rom[i] = 64'h0;
    rec_rom[0]  = mk(8'd1, 24'h001234, 32'h0);                 // R2 read
    rec_rom[1]  = mk(8'd2, 24'h000040, 32'hDEADBEEF);          // R3 write
    rec_rom[2]  = mk(8'd3, 24'h0ABCDE, 32'h11223344);          // R4 mailbox
    rec_rom[3]  = mk(8'd4, 24'h000800, {16'd5, 16'h0010});     // R5 string
    rec_rom[4]  = mk(8'd5, 24'hFFFFF8, {16'd3, 16'h0020});     // R6 wraps
    rec_rom[5]  = mk(8'd6, 24'h001000, 32'd37);                // R7 16+16+5
    rec_rom[6]  = mk(8'd6, 24'h004000, 32'd64);                // R9 at limit
    rec_rom[7]  = mk(8'd6, 24'h005000, 32'd65);                // R9 over
    rec_rom[8]  = mk(8'd7, 24'h006000, 32'd4);                 // R10 op 7
    rec_rom[9]  = mk(8'd8, 24'h003000, {16'd20, 16'h0040});    // R8 16+4
    rec_rom[10] = mk(8'd8, 24'h003800, {16'd70, 16'h0040});    // R9 over
    rec_rom[11] = mk(8'd4, 24'h007000, {16'd0, 16'h0000});     // R5 empty
    rec_rom[12] = mk(8'd0, 24'h000000, 32'h0);                 // R10 op 0
    rec_rom[13] = mk(8'd6, 24'h008000, 32'd0);                 // R7 empty
    rec_rom[14] = mk(8'hFF, 24'h009000, 32'h0);                // R10 op 255
    rec_rom[15] = mk(8'd2, 24'h00A000, 32'hCAFEF00D);          // R10 continue
    rec_rom[16] = mk(8'd6, 24'h00B000, 32'd16);                // R7 one chunk

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R12 reset state
    check(!busy && !done && !err, 12, "reset outputs", {busy, done, err}, 64'h0);
    check(!bus_rd && !bus_wr, 11, "reset bus idle", {bus_rd, bus_wr}, 64'h0);

    run(8'd0,  8'd3,  0, 0, 4);    // R2 R3 R4
    run(8'd3,  8'd7,  1, 0, 9);    // R5 R6 R7 R9
    run(8'd7,  8'd9,  2, 0, 10);   // R9 R10 error runs
    run(8'd9,  8'd17, 1, 0, 10);   // R8 R10 continue after errors
    run(8'd0,  8'd3,  2, 0, 12);   // R12 err cleared by start
    run(8'd5,  8'd5,  0, 0, 1);    // R1 empty range
    run(8'd10, 8'd4,  0, 0, 1);    // R1 first beyond last
    run(8'd0,  8'd17, 1, 1, 12);   // R1 full list, R12 start ignored
    run(8'd5,  8'd7,  0, 0, 7);    // R7 fills at full rate

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule